// File: doc/BRIEF.md
# Programmable-Order Fractional Divide-Ratio Modulator

This block sits next to the feedback divider of a fractional-N synthesizer. Once per reference cycle it delivers an integer divide value. Over many cycles the average of these values equals a programmed integer part plus a fraction, numerator over denominator. The denominator may be any value up to 22 bits wide and need not be a power of two.

The block is a cascade of three modulo-denominator accumulators. Their carries pass through first-difference networks. The noise-shaping order can be selected:

- integer only,
- first order,
- second order,
- third order.

A pseudo-random least-significant-bit dither, taken from a free-running LFSR, can be added to the first accumulator input at one of three densities. A strobe marks a write to the main control word. That strobe clears every accumulator and delay register and reseeds the LFSR, so the spur pattern restarts identically after each programming.

Top module: `frac_mod_top`

## Requirements
- R1: During reset `div_out` is 0. The cycle after a cycle with `ctrl_wr` high, `div_out` equals the `int_word` sampled with the strobe. All accumulators restart from zero and the LFSR is reseeded.
- R2: With `order_sel` = 0 (integer mode), `div_out` equals the previous cycle's `int_word` on every cycle.
- R3: With `order_sel` = 1, stage one adds the effective numerator each cycle. A carry occurs when the sum reaches the denominator, and the denominator is then subtracted. The output offset equals the carry (0 or 1).
- R4: With `order_sel` = 2, the offset is the stage-one carry plus the stage-two carry minus the previous stage-two carry, in the range -1 to +2. Stage two accumulates stage one's new residue.
- R5: With `order_sel` = 3, the offset adds the second difference of the stage-three carry: current, minus twice the previous, plus the one before that. Stage three accumulates stage two's new residue. The offset stays in the range -3 to +4.
- R6: `div_out` is registered. It equals `int_word` plus the offset computed from the inputs of the previous cycle, modulo 2^INT_W, and it follows changes to `int_word` one cycle later.
- R7: With dither off, after a write, the offsets of the first D outputs (D = denominator) sum to exactly the numerator for orders 1 and 2, and to within ±1 of it for order 3.
- R8: A denominator of 0 acts as 1. A numerator at or above the denominator acts as the denominator minus one.
- R9: With numerator 0 and dither off, after a write, `div_out` equals `int_word` on every cycle at every order.
- R10: `dither_sel` 0 disables dither. Values 1, 2 and 3 add a 1 to the stage-one input with probability 1/2, 1/4 and 1/8, taken from LFSR bits. A dithered run changes the carry pattern, stays within the offset range of its order, and repeats cycle for cycle after each write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Main control word write strobe; clears modulator state |
| order_sel | input | 2 | 0 integer, 1 first, 2 second, 3 third order |
| dither_sel | input | 2 | 0 off, 1 half, 2 quarter, 3 eighth density |
| int_word | input | INT_W | Integer part of the divide ratio |
| num_word | input | DEN_W | Fractional numerator |
| den_word | input | DEN_W | Fractional denominator |
| div_out | output | INT_W | Instantaneous divide value |

## Verification
The assertions assume that `int_word` sits at least 3 above zero and 4 below its maximum, so the offset never wraps the output. They also assume the denominator changes only together with a control write, since a residue bound is checked against the previous denominator. The stimulus uses integer words in the middle of the range. It reprograms the numerator, denominator and order only in the cycle that carries the write strobe, and varies only the integer word between writes. For the dithered runs the exact sequence is not predicted. They are instead checked for offset range, for repetition after a rewrite, and for a difference from the undithered run.

// File: rtl/frac_mod_pkg.sv
package frac_mod_pkg;

  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    ORD_INT   = 2'd0,
    ORD_ONE   = 2'd1,
    ORD_TWO   = 2'd2,
    ORD_THREE = 2'd3
  } order_e;

  typedef enum logic [1:0] {
    DITH_OFF     = 2'd0,
    DITH_HALF    = 2'd1,
    DITH_QUARTER = 2'd2,
    DITH_EIGHTH  = 2'd3
  } dither_e;

  // One Galois step, right-shifting
  function automatic logic [LFSR_W-1:0] lfsr_step(logic [LFSR_W-1:0] s);
    return s[0] ? ((s >> 1) ^ LFSR_TAPS) : (s >> 1);
  endfunction

  // Dither bit for a density code
  function automatic logic dither_pick(logic [1:0] mode, logic [LFSR_W-1:0] s);
    case (mode)
      2'd1:    return s[0];
      2'd2:    return s[0] & s[1];
      2'd3:    return &s[2:0];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/frac_mod_accum.sv
module frac_mod_accum #(
  parameter int DEN_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [DEN_W-1:0] den,
  input  logic [DEN_W:0]   addend,
  output logic [DEN_W-1:0] acc_q,
  output logic [DEN_W-1:0] acc_nxt,
  output logic             carry
);

  localparam int SUM_W = DEN_W + 2;

  // Returns {carry, residue}; needs a < d and b <= d
  function automatic logic [DEN_W:0] fold(logic [DEN_W-1:0] a,
                                          logic [DEN_W:0]   b,
                                          logic [DEN_W-1:0] d);
    logic [SUM_W-1:0] s;
    logic [SUM_W-1:0] r;
    s = SUM_W'(a) + SUM_W'(b);
    if (s >= SUM_W'(d)) begin
      r = s - SUM_W'(d);
      return {1'b1, r[DEN_W-1:0]};
    end
    return {1'b0, s[DEN_W-1:0]};
  endfunction

  logic [DEN_W:0] folded;

  assign folded  = fold(acc_q, addend, den);
  assign carry   = en & folded[DEN_W];
  assign acc_nxt = en ? folded[DEN_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr || !en) acc_q <= '0;
    else                 acc_q <= acc_nxt;
  end

endmodule

// File: rtl/frac_mod_dither.sv
module frac_mod_dither
  import frac_mod_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [1:0]        mode,
  output logic              dith_bit,
  output logic [LFSR_W-1:0] lfsr_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   lfsr_q <= SEED;
    else if (clr) lfsr_q <= SEED;
    else          lfsr_q <= lfsr_step(lfsr_q);
  end

  assign dith_bit = dither_pick(mode, lfsr_q);

endmodule

// File: rtl/frac_mod_shaper.sv
module frac_mod_shaper
  import frac_mod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [1:0]        order,
  input  logic [2:0]        carries,
  output logic signed [3:0] offset
);

  logic c2_d;
  logic c3_d1;
  logic c3_d2;
  logic signed [3:0] term1;
  logic signed [3:0] term2;
  logic signed [3:0] term3;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || 1'b0) begin
      c2_d  <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else if (clr || !en) begin
      c2_d  <= 1'b0;
      c3_d1 <= 1'b0;
      c3_d2 <= 1'b0;
    end else begin
      c2_d  <= carries[1];
      c3_d1 <= carries[2];
      c3_d2 <= c3_d1;
    end
  end

  assign term1 = {3'b000, carries[0]};
  assign term2 = $signed({3'b000, carries[1]}) - $signed({3'b000, c2_d});
  assign term3 = $signed({3'b000, carries[2]}) - $signed({2'b00, c3_d1, 1'b0})
               + $signed({3'b000, c3_d2});

  always_comb begin
    offset = '0;
    if (en) begin
      case (order_e'(order))
        ORD_ONE:   offset = term1;
        ORD_TWO:   offset = term1 + term2;
        ORD_THREE: offset = term1 + term2 + term3;
        default:   offset = '0;
      endcase
    end
  end

endmodule

// File: rtl/frac_mod_top.sv
module frac_mod_top
  import frac_mod_pkg::*;
#(
  parameter int INT_W = 16,
  parameter int DEN_W = 22,
  parameter logic [LFSR_W-1:0] DITH_SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [1:0]       order_sel,
  input  logic [1:0]       dither_sel,
  input  logic [INT_W-1:0] int_word,
  input  logic [DEN_W-1:0] num_word,
  input  logic [DEN_W-1:0] den_word,
  output logic [INT_W-1:0] div_out
);

  localparam int NSTAGE = 3;

  logic [DEN_W-1:0]             den_eff;
  logic [DEN_W-1:0]             num_eff;
  logic                         mod_on;
  logic                         dith_raw;
  logic                         dith_bit;
  logic [LFSR_W-1:0]            lfsr_q;
  logic [NSTAGE-1:0][DEN_W:0]   stage_in;
  logic [NSTAGE-1:0][DEN_W-1:0] acc_q;
  logic [NSTAGE-1:0][DEN_W-1:0] acc_nxt;
  logic [NSTAGE-1:0]            carry_vec;
  logic signed [3:0]            offset;

  assign den_eff  = (den_word == '0) ? DEN_W'(1) : den_word;
  assign num_eff  = (num_word >= den_eff) ? den_eff - DEN_W'(1) : num_word;
  assign mod_on   = (order_sel != ORD_INT);
  assign dith_bit = mod_on & dith_raw;

  frac_mod_dither #(.SEED(DITH_SEED)) u_dith (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ctrl_wr),
    .mode     (dither_sel),
    .dith_bit (dith_raw),
    .lfsr_q   (lfsr_q)
  );

  assign stage_in[0] = {1'b0, num_eff} + {{DEN_W{1'b0}}, dith_bit};

  for (genvar i = 1; i < NSTAGE; i++) begin : g_chain
    assign stage_in[i] = {1'b0, acc_nxt[i-1]};
  end

  for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
    frac_mod_accum #(.DEN_W(DEN_W)) u_acc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (ctrl_wr),
      .en      (mod_on),
      .den     (den_eff),
      .addend  (stage_in[i]),
      .acc_q   (acc_q[i]),
      .acc_nxt (acc_nxt[i]),
      .carry   (carry_vec[i])
    );
  end

  frac_mod_shaper u_shape (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ctrl_wr),
    .en      (mod_on),
    .order   (order_sel),
    .carries (carry_vec),
    .offset  (offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_out <= '0;
    else if (ctrl_wr) div_out <= int_word;
    else              div_out <= int_word + {{(INT_W-4){offset[3]}}, offset};
  end

endmodule

// File: rtl/frac_mod_chk.sv
module frac_mod_chk #(
  parameter int INT_W  = 16,
  parameter int DEN_W  = 22,
  parameter int LFSR_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   ctrl_wr,
  input logic [1:0]             order_sel,
  input logic [1:0]             dither_sel,
  input logic [INT_W-1:0]       int_word,
  input logic [DEN_W-1:0]       den_eff,
  input logic [DEN_W-1:0]       num_eff,
  input logic [2:0][DEN_W-1:0]  acc_q,
  input logic signed [3:0]      offset,
  input logic [LFSR_W-1:0]      lfsr_q,
  input logic [INT_W-1:0]       div_out
);

  // R1
  wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (acc_q == '0) && (div_out == $past(int_word)));

  // R2
  int_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_sel == 2'd0) |=> (div_out == $past(int_word)));

  // R3
  first_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_sel == 2'd1 && dither_sel == 2'd0) |-> (offset >= 4'sd0 && offset <= 4'sd1));

  // R4
  second_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (order_sel == 2'd2 && dither_sel == 2'd0) |-> (offset >= -4'sd1 && offset <= 4'sd2));

  // R5
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (offset >= -4'sd3) && (offset <= 4'sd4));

  // R8
  num_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    num_eff < den_eff);

  // R8
  residue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q[0] < $past(den_eff)) && (acc_q[1] < $past(den_eff)) && (acc_q[2] < $past(den_eff)));

  // R10
  lfsr_alive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);

endmodule

bind frac_mod_top frac_mod_chk #(
  .INT_W  (INT_W),
  .DEN_W  (DEN_W),
  .LFSR_W (frac_mod_pkg::LFSR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ctrl_wr    (ctrl_wr),
  .order_sel  (order_sel),
  .dither_sel (dither_sel),
  .int_word   (int_word),
  .den_eff    (den_eff),
  .num_eff    (num_eff),
  .acc_q      (acc_q),
  .offset     (offset),
  .lfsr_q     (lfsr_q),
  .div_out    (div_out)
);

// File: tb/frac_mod_top_tb.sv
`timescale 1ns/1ps
module frac_mod_top_tb;
  localparam int INT_W = 16;
  localparam int DEN_W = 22;

  logic clk = 1'b0;
  logic rst_n;
  logic ctrl_wr;
  logic [1:0] order_sel;
  logic [1:0] dither_sel;
  logic [INT_W-1:0] int_word;
  logic [DEN_W-1:0] num_word;
  logic [DEN_W-1:0] den_word;
  logic [INT_W-1:0] div_out;

  always #2.5 clk = ~clk;

  frac_mod_top #(.INT_W(INT_W), .DEN_W(DEN_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .order_sel(order_sel),
    .dither_sel(dither_sel), .int_word(int_word), .num_word(num_word),
    .den_word(den_word), .div_out(div_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_r1, m_r2, m_r3, m_hist2, m_h3a, m_h3b;
  int seq[$];
  int prev_seq[$];

  function automatic void model_clear();
    m_r1 = 0; m_r2 = 0; m_r3 = 0; m_hist2 = 0; m_h3a = 0; m_h3b = 0;
  endfunction

  function automatic int model_step();
    int d, n, k1, k2, k3, off;
    d = (den_word == 0) ? 1 : int'(den_word);
    n = (int'(num_word) >= d) ? d - 1 : int'(num_word);
    if (ctrl_wr || order_sel == 2'd0) begin
      model_clear();
      return int'(int_word);
    end
    m_r1 = m_r1 + n;    k1 = m_r1 / d; m_r1 = m_r1 % d;
    m_r2 = m_r2 + m_r1; k2 = m_r2 / d; m_r2 = m_r2 % d;
    m_r3 = m_r3 + m_r2; k3 = m_r3 / d; m_r3 = m_r3 % d;
    off = k1;
    if (order_sel >= 2'd2) off = off + (k2 - m_hist2);
    if (order_sel == 2'd3) off = off + (k3 - 2 * m_h3a + m_h3b);
    m_hist2 = k2; m_h3b = m_h3a; m_h3a = k3;
    return (int'(int_word) + off) & 16'hFFFF;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(string tag, bit cmp);
    int e;
    e = model_step();
    @(posedge clk);
    @(negedge clk);
    if (cmp) check(tag, int'(div_out), e);
  endtask

  // write, then run; seq collects offsets
  task automatic run(string tag, int ord, int dth, int iw, int nm, int dn, int cycles);
    order_sel = 2'(ord); dither_sel = 2'(dth);
    int_word = 16'(iw); num_word = 22'(nm); den_word = 22'(dn);
    ctrl_wr = 1'b1;
    tick({tag, " write R1"}, 1'b1);
    ctrl_wr = 1'b0;
    seq.delete();
    for (int i = 0; i < cycles; i++) begin
      tick(tag, dth == 0);
      seq.push_back(int'(div_out) - iw);
    end
  endtask

  function automatic int seq_sum(int len);
    int s = 0;
    for (int i = 0; i < len; i++) s += seq[i];
    return s;
  endfunction

  task automatic range_check(string tag, int lo, int hi);
    int ok = 1;
    foreach (seq[i]) if (seq[i] < lo || seq[i] > hi) ok = 0;
    check(tag, ok, 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int diffs;
    rst_n = 1'b0; ctrl_wr = 1'b0; order_sel = 2'd0; dither_sel = 2'd0;
    int_word = 16'd100; num_word = '0; den_word = 22'd1;
    model_clear();
    repeat (3) @(negedge clk);
    check("R1 reset value", int'(div_out), 0);
    rst_n = 1'b1;

    // R2 integer mode ignores fraction
    run("R2 integer mode", 0, 0, 200, 5, 7, 20);
    check("R2 zero offset sum", seq_sum(20), 0);

    // R3 / R7 first order
    run("R3 first order", 1, 0, 300, 3, 7, 21);
    check("R7 order1 period sum", seq_sum(7), 3);
    range_check("R3 offset range", 0, 1);

    // R4 / R7 second order
    run("R4 second order", 2, 0, 400, 5, 11, 33);
    check("R7 order2 period sum", seq_sum(11), 5);
    range_check("R4 offset range", -1, 2);

    // R5 / R7 third order, non-power-of-two denominator
    run("R5 third order", 3, 0, 500, 1234, 4000, 4000);
    check("R7 order3 period sum within 1", (seq_sum(4000) - 1234) inside {-1, 0, 1}, 1);
    range_check("R5 offset range", -3, 4);

    run("R5 third order small", 3, 0, 600, 7, 13, 39);
    check("R7 order3 small sum within 1", (seq_sum(13) - 7) inside {-1, 0, 1}, 1);

    // R5 maximal denominator
    run("R5 max denominator", 3, 0, 700, 4194302, 4194303, 200);
    range_check("R5 max den range", -3, 4);

    // R6 integer word follows one cycle later
    run("R6 int change", 1, 0, 800, 2, 5, 0);
    for (int i = 0; i < 30; i++) begin
      if (i % 5 == 0) int_word = 16'(800 + i);
      tick("R6 int tracking", 1'b1);
    end

    // R8 clamps
    run("R8 num clamp", 1, 0, 900, 20, 9, 18);
    check("R8 clamped period sum", seq_sum(9), 8);
    run("R8 zero den", 3, 0, 950, 3, 0, 10);
    check("R8 zero den sum", seq_sum(10), 0);

    // R9 zero numerator
    run("R9 zero numerator", 3, 0, 1000, 0, 97, 50);
    check("R9 zero sum", seq_sum(50), 0);

    // R10 dither repeatability and effect
    run("R10 dither half", 3, 1, 1100, 5, 11, 64);
    range_check("R10 dither range", -3, 4);
    prev_seq = seq;
    run("R10 dither repeat", 3, 1, 1100, 5, 11, 64);
    diffs = 0;
    foreach (seq[i]) if (seq[i] != prev_seq[i]) diffs++;
    check("R10 repeat after write", diffs, 0);
    run("R10 undithered ref", 3, 0, 1100, 5, 11, 64);
    diffs = 0;
    foreach (seq[i]) if (seq[i] != prev_seq[i]) diffs++;
    check("R10 dither changes pattern", diffs > 0, 1);
    run("R10 dither quarter", 1, 2, 1200, 5, 11, 64);
    range_check("R10 quarter range", 0, 1);
    run("R10 dither eighth", 2, 3, 1300, 5, 11, 64);
    range_check("R10 eighth range", -1, 2);

    finished = 1;
    summary();
    $finish;
  end

endmodule